// File: doc/BRIEF.md
# Asynchronous serial receiver with status flags and idle-line detection

This block takes a serial input at a 16x oversampling rate and recovers characters of one start bit, eight data bits sent least significant bit first, and one stop bit. Each finished character lands in a parallel holding register, and five status flags describe it. A full flag says the register holds an unread character. An overrun flag says a later character arrived before the read and was dropped. A noise flag and a framing flag give extra detail on the held character. An idle flag reports that the line has gone quiet.

A host reads the holding register and pulses `rd_strobe` to take the character. This clears the four character flags. The idle flag is cleared with its own strobe. A single interrupt output combines full or overrun under one mask with idle under a second mask. Noise and framing errors never raise it.

The oversample enable `os_tick` comes from outside. Baud generation, parity and multi-drop wake-up are not part of the block.

Top module: `uart_rx_status`

## Requirements
- R1: After reset `rx_data` is 0, all five flags are 0 and `irq` is 0.
- R2: A frame of a low start bit, eight data bits (bit 0 first) and a high stop bit, each bit lasting 16 `os_tick` periods, is loaded into `rx_data` with `flag_full` set, provided `flag_full` was clear when the stop bit was sampled.
- R3: If a frame completes while `flag_full` is set, the new character is dropped. `rx_data`, `flag_noise` and `flag_frame` keep their values, `flag_ovr` goes to 1 and `flag_full` stays 1.
- R4: Each bit is sampled at oversample ticks 7, 8 and 9 of its bit period and resolved by a 2-of-3 vote. If the three samples of any bit of the frame disagree, `flag_noise` is set for that character, and the voted data value is kept.
- R5: A stop bit that votes 0 sets `flag_frame`, and the character is still loaded into `rx_data`.
- R6: A start bit that votes 1 is treated as a glitch. The receiver goes back to waiting for a falling edge and no character is produced.
- R7: A `rd_strobe` pulse clears `flag_full`, `flag_ovr`, `flag_noise` and `flag_frame`.
- R8: `flag_idle` is set once the line has been high for 160 consecutive oversample ticks, counting from the most recent low sample, and only if a low sample has been seen since the last time it was set. The flag stays set until a `clr_idle` pulse. It is not set again until the line has been low once more.
- R9: `irq` equals (`flag_full` or `flag_ovr`) AND `rx_irq_en`, OR'd with `flag_idle` AND `idle_irq_en`.
- R10: `flag_noise` and `flag_frame` on their own never drive `irq`. They are only ever set while `flag_full` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | Host has taken the held character |
| clr_idle | input | 1 | Clears the idle flag |
| rx_irq_en | input | 1 | Interrupt mask for full and overrun |
| idle_irq_en | input | 1 | Interrupt mask for idle |
| rx_data | output | 8 | Held character |
| flag_full | output | 1 | Unread character present |
| flag_ovr | output | 1 | A character was dropped |
| flag_noise | output | 1 | Held character had disagreeing samples |
| flag_frame | output | 1 | Held character had a low stop bit |
| flag_idle | output | 1 | Line went idle after activity |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong bit counter or sample point shows up within one frame as a shifted or corrupted byte in `rx_data`, or as a missing `flag_full`. The scoreboard catches this at the moment the character arrives. A wrong full-state decision on overrun shows up at the next frame's stop bit as a changed `rx_data` or a missing `flag_ovr`. A wrongly armed idle counter shows up about 160 ticks after the last low bit: either `flag_idle` appears on a line that has never been active, or it comes back after a clear without any new traffic.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_BITS = 8;
    localparam int STOP_BITS = 1;
    localparam int FRAME_BITS = DATA_BITS + STOP_BITS + 1;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 noise;
        logic                 frame_err;
    } rx_char_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic split3(input logic [2:0] s);
        return (s != 3'b000) && (s != 3'b111);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    output logic     char_valid,
    output rx_char_t char_out
);
    localparam int CW  = $clog2(OS_RATE);
    localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int MID = OS_RATE / 2;

    rx_state_e              st_q;
    logic [CW-1:0]          cnt_q;
    logic [BW-1:0]          bitn_q;
    logic [1:0]             smp_q;
    logic [DATA_BITS-1:0]   shreg_q;
    logic                   noise_q;

    logic [2:0] trio;
    logic       vote, split;
    logic       decide, bit_end;

    always_comb begin
        trio    = {smp_q, line};
        vote    = vote3(trio);
        split   = split3(trio);
        decide  = tick && (st_q != ST_HUNT) && (cnt_q == CW'(MID + 1));
        bit_end = tick && (st_q != ST_HUNT) && (cnt_q == CW'(OS_RATE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_HUNT;
            cnt_q      <= '0;
            bitn_q     <= '0;
            smp_q      <= 2'b11;
            shreg_q    <= '0;
            noise_q    <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            if (tick) begin
                if (st_q == ST_HUNT) begin
                    cnt_q   <= '0;
                    bitn_q  <= '0;
                    noise_q <= 1'b0;
                    if (!line) st_q <= ST_START;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(MID - 1) || cnt_q == CW'(MID))
                        smp_q <= {smp_q[0], line};
                end
            end

            // R4: three-sample vote at ticks 7, 8, 9
            if (decide) begin
                noise_q <= noise_q | split;
                unique case (st_q)
                    ST_START: if (vote) st_q <= ST_HUNT;  // R6 glitch reject
                    ST_DATA:  shreg_q <= {vote, shreg_q[DATA_BITS-1:1]};
                    ST_STOP: begin
                        char_valid         <= 1'b1;
                        char_out.data      <= shreg_q;
                        char_out.noise     <= noise_q | split;
                        char_out.frame_err <= ~vote;       // R5
                        st_q               <= ST_HUNT;
                    end
                    default: ;
                endcase
            end else if (bit_end) begin
                unique case (st_q)
                    ST_START: st_q <= ST_DATA;
                    ST_DATA: begin
                        bitn_q <= bitn_q + 1'b1;
                        if (bitn_q == BW'(DATA_BITS - 1)) st_q <= ST_STOP;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: a completed character always leaves the engine hunting
    assert_done_to_hunt_R2: assert property (@(posedge clk) disable iff (rst)
        char_valid |-> (st_q == ST_HUNT));

    // R6: engine only leaves hunting on a low line
    assert_start_on_low_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HUNT && tick && line) |=> (st_q == ST_HUNT));
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
    parameter int LIMIT = 160
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    output logic idle_pulse
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] high_cnt_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt_q <= '0;
            armed_q    <= 1'b0;
            idle_pulse <= 1'b0;
        end else begin
            idle_pulse <= 1'b0;
            if (tick) begin
                if (!line) begin
                    high_cnt_q <= '0;
                    armed_q    <= 1'b1;
                end else if (high_cnt_q != CW'(LIMIT)) begin
                    high_cnt_q <= high_cnt_q + 1'b1;
                    if (high_cnt_q == CW'(LIMIT - 1) && armed_q) begin
                        idle_pulse <= 1'b1;
                        armed_q    <= 1'b0;
                    end
                end
            end
        end
    end

    // R8: a low sample can never be followed by the idle pulse
    assert_idle_needs_high_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !line) |=> !idle_pulse);

    // R8: one pulse per idle period
    assert_idle_single_R8: assert property (@(posedge clk) disable iff (rst)
        idle_pulse |=> !idle_pulse);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 char_valid,
    input  rx_char_t             char_in,
    input  logic                 idle_pulse,
    input  logic                 rd,
    input  logic                 clr_idle,
    input  logic                 rx_en,
    input  logic                 idle_en,
    output logic [DATA_BITS-1:0] data_q,
    output logic                 full_q,
    output logic                 ovr_q,
    output logic                 noise_q,
    output logic                 frame_q,
    output logic                 idle_q,
    output logic                 irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
            noise_q <= 1'b0;
            frame_q <= 1'b0;
            idle_q  <= 1'b0;
        end else begin
            if (rd) begin                       // R7
                full_q  <= 1'b0;
                ovr_q   <= 1'b0;
                noise_q <= 1'b0;
                frame_q <= 1'b0;
            end
            if (char_valid) begin
                if (full_q && !rd) begin
                    ovr_q <= 1'b1;              // R3: drop new char
                end else begin
                    data_q  <= char_in.data;    // R2
                    full_q  <= 1'b1;
                    noise_q <= char_in.noise;
                    frame_q <= char_in.frame_err;
                end
            end
            if (clr_idle)   idle_q <= 1'b0;
            if (idle_pulse) idle_q <= 1'b1;     // R8
        end
    end

    assign irq = (rx_en & (full_q | ovr_q)) | (idle_en & idle_q);   // R9

    assert_ovr_keeps_data_R3: assert property (@(posedge clk) disable iff (rst)
        (char_valid && full_q && !rd) |=> (data_q == $past(data_q)) && ovr_q && full_q);

    assert_ovr_implies_full_R3: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> full_q);

    assert_info_needs_full_R10: assert property (@(posedge clk) disable iff (rst)
        (noise_q || frame_q) |-> full_q);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && !char_valid) |=> !full_q && !ovr_q && !noise_q && !frame_q);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !idle_en) |-> !irq);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 os_tick,
    input  logic                 rx_in,
    input  logic                 rd_strobe,
    input  logic                 clr_idle,
    input  logic                 rx_irq_en,
    input  logic                 idle_irq_en,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 flag_full,
    output logic                 flag_ovr,
    output logic                 flag_noise,
    output logic                 flag_frame,
    output logic                 flag_idle,
    output logic                 irq
);
    localparam int IDLE_TICKS = FRAME_BITS * OS_RATE;

    logic     line_s;
    logic     char_valid;
    rx_char_t char_w;
    logic     idle_pulse;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (line_s)
    );

    uart_rx_frame #(.OS_RATE(OS_RATE)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .tick       (os_tick),
        .line       (line_s),
        .char_valid (char_valid),
        .char_out   (char_w)
    );

    uart_rx_idle #(.LIMIT(IDLE_TICKS)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .tick       (os_tick),
        .line       (line_s),
        .idle_pulse (idle_pulse)
    );

    uart_rx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .char_valid (char_valid),
        .char_in    (char_w),
        .idle_pulse (idle_pulse),
        .rd         (rd_strobe),
        .clr_idle   (clr_idle),
        .rx_en      (rx_irq_en),
        .idle_en    (idle_irq_en),
        .data_q     (rx_data),
        .full_q     (flag_full),
        .ovr_q      (flag_ovr),
        .noise_q    (flag_noise),
        .frame_q    (flag_frame),
        .idle_q     (flag_idle),
        .irq        (irq)
    );
endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int OS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       man_rd = 1'b0;
    logic       auto_rd = 1'b0;
    logic       clr_idle = 1'b0;
    logic       rx_irq_en = 1'b0;
    logic       idle_irq_en = 1'b0;
    logic [7:0] rx_data;
    logic       flag_full, flag_ovr, flag_noise, flag_frame, flag_idle, irq;
    logic       rd_strobe;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  auto_read = 1'b1;
    bit  finished = 1'b0;
    logic [9:0] sb_q[$];

    assign rd_strobe = man_rd | auto_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_status uut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_in(rx_in),
        .rd_strobe(rd_strobe), .clr_idle(clr_idle),
        .rx_irq_en(rx_irq_en), .idle_irq_en(idle_irq_en),
        .rx_data(rx_data), .flag_full(flag_full), .flag_ovr(flag_ovr),
        .flag_noise(flag_noise), .flag_frame(flag_frame),
        .flag_idle(flag_idle), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input bit glitch);
        for (int c = 0; c < OS; c++) begin
            @(negedge clk);
            rx_in = (glitch && c == 9) ? ~v : v;
        end
    endtask

    task automatic hold_high(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            rx_in = 1'b1;
        end
    endtask

    // driver: pushes expected {data, noise, frame} then drives the frame
    task automatic send_frame(input logic [7:0] d, input int noisy_bit,
                              input bit bad_stop, input bit push);
        if (push) sb_q.push_back({d, noisy_bit >= 0, bad_stop});
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i], noisy_bit == i);
        drive_bit(~bad_stop, 1'b0);
    endtask

    // monitor: pops and compares each arriving character, then reads it
    initial begin
        forever begin
            @(negedge clk);
            if (auto_read && flag_full && !auto_rd) begin
                if (sb_q.size() == 0) begin
                    chk("R6 unexpected character", {22'd0, rx_data, flag_noise, flag_frame}, 32'hFFFF_FFFF);
                end else begin
                    logic [9:0] e;
                    e = sb_q.pop_front();
                    chk("R2 data", {24'd0, rx_data}, {24'd0, e[9:2]});
                    chk("R4 noise", {31'd0, flag_noise}, {31'd0, e[1]});
                    chk("R5 frame", {31'd0, flag_frame}, {31'd0, e[0]});
                    chk("R9/R10 irq while full", {31'd0, irq}, {31'd0, rx_irq_en});
                end
                auto_rd = 1'b1;
            end else begin
                auto_rd = 1'b0;
            end
        end
    end

    task automatic pulse_clr_idle();
        @(negedge clk); clr_idle = 1'b1;
        @(negedge clk); clr_idle = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", {24'd0, rx_data}, 32'd0);
        chk("R1 flags", {27'd0, flag_full, flag_ovr, flag_noise, flag_frame, flag_idle}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R8: no activity yet, so idle must stay clear
        hold_high(300);
        chk("R8 idle without activity", {31'd0, flag_idle}, 32'd0);

        // R2 several patterns back to back
        rx_irq_en = 1'b1;
        send_frame(8'hA5, -1, 1'b0, 1'b1);
        send_frame(8'h3C, -1, 1'b0, 1'b1);
        send_frame(8'h00, -1, 1'b0, 1'b1);
        send_frame(8'h80, -1, 1'b0, 1'b1);
        hold_high(20);
        chk("R2 scoreboard drained", sb_q.size(), 32'd0);

        // R4 noise and R10 with masks off
        rx_irq_en = 1'b0;
        send_frame(8'h5A, 3, 1'b0, 1'b1);
        hold_high(20);
        send_frame(8'hC3, 7, 1'b0, 1'b1);
        hold_high(20);
        // R5 framing error, still loaded
        send_frame(8'h81, -1, 1'b1, 1'b1);
        hold_high(40);
        chk("R5 scoreboard drained", sb_q.size(), 32'd0);

        // R6 start glitch: short low pulse
        for (int c = 0; c < 4; c++) begin @(negedge clk); rx_in = 1'b0; end
        hold_high(300);
        chk("R6 no char after glitch", {31'd0, flag_full}, 32'd0);

        // R3 overrun, manual read
        pulse_clr_idle();
        auto_read = 1'b0;
        rx_irq_en = 1'b1;
        send_frame(8'h11, -1, 1'b1, 1'b0);
        hold_high(20);
        chk("R5 first char frame", {31'd0, flag_frame}, 32'd1);
        send_frame(8'h22, -1, 1'b0, 1'b0);
        hold_high(20);
        chk("R3 data kept", {24'd0, rx_data}, 32'h11);
        chk("R3 ovr set", {31'd0, flag_ovr}, 32'd1);
        chk("R3 full stays", {31'd0, flag_full}, 32'd1);
        chk("R3 frame kept", {31'd0, flag_frame}, 32'd1);
        chk("R9 irq on overrun", {31'd0, irq}, 32'd1);
        rx_irq_en = 1'b0;
        @(negedge clk);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
        chk("R7 read clears", {28'd0, flag_full, flag_ovr, flag_noise, flag_frame}, 32'd0);
        auto_read = 1'b1;

        // R8 idle after activity
        hold_high(200);
        pulse_clr_idle();
        send_frame(8'hFF, -1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R8 idle not early", {31'd0, flag_idle}, 32'd0);
        hold_high(80);
        chk("R8 idle set", {31'd0, flag_idle}, 32'd1);
        chk("R8 char arrived", sb_q.size(), 32'd0);
        chk("R9 idle masked", {31'd0, irq}, 32'd0);
        idle_irq_en = 1'b1;
        @(negedge clk);
        chk("R9 irq on idle", {31'd0, irq}, 32'd1);
        idle_irq_en = 1'b0;
        pulse_clr_idle();
        hold_high(400);
        chk("R8 idle only once", {31'd0, flag_idle}, 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule